// File: doc/BRIEF.md
# Display RAM Address Sequencer

This block produces the bank and column address of a display memory of 102 columns by 9 banks (each byte covering 8 pixel rows) while a host streams data bytes into it. A column pointer and a bank pointer hold the next location. Every data-byte strobe raises the write enable for that cycle, with the address taken from the pointers as they stand. On the following clock edge the pointers then step to the next location.

The step order is selectable. In horizontal order the column moves first and the bank moves when the column wraps. In vertical order the bank moves first and the column moves when the bank wraps. Both wrap points are programmable limits rather than the array edges. Setting the bank limit one short of the last bank keeps the final bank free, for example for icon data. A mirror bit turns the column address round so that it runs from the far edge. Host commands load the pointers, the two limits and the mode bits directly. Loaded values are clamped into the array.

Top module: `dras_addr_seq`

## Requirements
- R1: After reset the column pointer and bank pointer are 0, the order is horizontal, mirroring is off, the column limit is 101 and the bank limit is 8; `wr_en` is 0 and `col_addr`/`bank_addr` read 0.
- R2: `wr_en` is 1 in exactly the cycles where `byte_stb` is 1. `col_addr` and `bank_addr` always show the current pointer location, so a byte is written at the location held before its own step. With no strobe of any kind, the pointers do not change.
- R3: In horizontal order (mode bit `mode_vert`=0), a byte with column pointer below the column limit moves the column pointer up by one and leaves the bank pointer unchanged. A byte with column pointer at or above the column limit returns the column pointer to 0 and moves the bank pointer up by one, or returns it to 0 if it is at or above the bank limit.
- R4: In vertical order (`mode_vert`=1), a byte with bank pointer below the bank limit moves the bank pointer up by one and leaves the column pointer unchanged. A byte with bank pointer at or above the bank limit returns the bank pointer to 0 and moves the column pointer up by one, or returns it to 0 if it is at or above the column limit.
- R5: With mirroring on (`mode_mirror`=1), `col_addr` equals 101 minus the column pointer. `bank_addr` and the stepping of the pointers are unaffected.
- R6: `setx_stb` loads the column pointer from `setx_val`, and `sety_stb` loads the bank pointer from `sety_val`. Values above 101 load as 101, and values above 8 load as 8.
- R7: `xlim_stb` loads the column limit from `xlim_val`, clamped to 101. `ylim_stb` loads the bank limit (4 bits) from `ylim_val`, clamped to 8.
- R8: `mode_stb` loads the order bit from `mode_vert` and the mirror bit from `mode_mirror`. The new mode governs both addresses and steps from the next cycle on.
- R9: If any command strobe is high in the same cycle as `byte_stb`, the byte is still written at the current location. The automatic step is suppressed, and only the command's loads take effect.
- R10: With the default limits, 918 consecutive bytes from location (0,0) reach every one of the 918 locations exactly once, in either order and with or without mirroring. The pointers then return to (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_stb | input | 1 | One data byte is being written this cycle |
| setx_stb | input | 1 | Load column pointer |
| setx_val | input | 7 | Column pointer value |
| sety_stb | input | 1 | Load bank pointer |
| sety_val | input | 4 | Bank pointer value |
| xlim_stb | input | 1 | Load column wrap limit |
| xlim_val | input | 7 | Column wrap limit value |
| ylim_stb | input | 1 | Load bank wrap limit |
| ylim_val | input | 4 | Bank wrap limit value |
| mode_stb | input | 1 | Load mode bits |
| mode_vert | input | 1 | 0 horizontal order, 1 vertical order |
| mode_mirror | input | 1 | 1 mirrors the column address |
| wr_en | output | 1 | Write enable to the display memory |
| col_addr | output | 7 | Physical column address |
| bank_addr | output | 4 | Bank address |

## Verification
On every cycle, the assertions check that the pointers stay inside the array, that a plain byte moves the pointers by one step or wraps them to zero as the order requires, that a mirrored column address and the pointer sum to 101, that a coinciding command freezes the automatic step, and that an idle cycle leaves the address still. Only the bench's scenarios can show the whole orderings. These are full sweeps that must touch each of the 918 locations exactly once under both orders and under mirroring, wrap sequences under reduced limits, and clamping of oversize loads. Loaded limits are only visible through the wrap they cause, so they too are checked by the scenarios.

// File: rtl/dras_pkg.sv
package dras_pkg;
    localparam int DEF_COLS  = 102;
    localparam int DEF_BANKS = 9;

    typedef enum logic {
        ORD_HORZ = 1'b0,
        ORD_VERT = 1'b1
    } order_e;
endpackage

// File: rtl/dras_clamp.sv
// Saturates a loaded value to the last valid index of its axis.
module dras_clamp #(
    parameter int W    = 7,
    parameter int MAXV = 101
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] lim
);
    localparam logic [W-1:0] TOP = W'(MAXV);

    always_comb begin
        lim = (raw > TOP) ? TOP : raw;
    end
endmodule

// File: rtl/dras_step.sv
// Next pointer location for one data byte, in either order.
module dras_step
    import dras_pkg::*;
#(
    parameter int CW = 7,
    parameter int BW = 4
) (
    input  logic [CW-1:0] x,
    input  logic [BW-1:0] y,
    input  logic [CW-1:0] xlim,
    input  logic [BW-1:0] ylim,
    input  order_e        ord,
    output logic [CW-1:0] nx,
    output logic [BW-1:0] ny
);
    logic x_end;
    logic y_end;
    logic [CW-1:0] x_inc;
    logic [BW-1:0] y_inc;

    always_comb begin
        x_end = (x >= xlim);
        y_end = (y >= ylim);
        x_inc = x_end ? '0 : x + 1'b1;
        y_inc = y_end ? '0 : y + 1'b1;
        if (ord == ORD_HORZ) begin
            nx = x_inc;
            ny = x_end ? y_inc : y;
        end else begin
            ny = y_inc;
            nx = y_end ? x_inc : x;
        end
    end
endmodule

// File: rtl/dras_mirror.sv
// Converts the column pointer into the physical column address.
module dras_mirror #(
    parameter int CW       = 7,
    parameter int NUM_COLS = 102
) (
    input  logic [CW-1:0] x,
    input  logic          mirror,
    output logic [CW-1:0] col
);
    localparam logic [CW-1:0] LAST = CW'(NUM_COLS - 1);

    always_comb begin
        col = mirror ? (LAST - x) : x;
    end
endmodule

// File: rtl/dras_addr_seq.sv
module dras_addr_seq
    import dras_pkg::*;
#(
    parameter int NUM_COLS  = DEF_COLS,
    parameter int NUM_BANKS = DEF_BANKS,
    localparam int CW = $clog2(NUM_COLS),
    localparam int BW = $clog2(NUM_BANKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_stb,
    input  logic          setx_stb,
    input  logic [CW-1:0] setx_val,
    input  logic          sety_stb,
    input  logic [BW-1:0] sety_val,
    input  logic          xlim_stb,
    input  logic [CW-1:0] xlim_val,
    input  logic          ylim_stb,
    input  logic [BW-1:0] ylim_val,
    input  logic          mode_stb,
    input  logic          mode_vert,
    input  logic          mode_mirror,
    output logic          wr_en,
    output logic [CW-1:0] col_addr,
    output logic [BW-1:0] bank_addr
);
    localparam int MAX_X = NUM_COLS - 1;
    localparam int MAX_Y = NUM_BANKS - 1;

    typedef struct packed {
        logic [CW-1:0] x;
        logic [BW-1:0] y;
        logic [CW-1:0] xlim;
        logic [BW-1:0] ylim;
        order_e        ord;
        logic          mirror;
    } seq_state_t;

    localparam seq_state_t RESET_ST = '{
        x:      '0,
        y:      '0,
        xlim:   CW'(MAX_X),
        ylim:   BW'(MAX_Y),
        ord:    ORD_HORZ,
        mirror: 1'b0
    };

    seq_state_t st_d, st_q;

    logic          any_cmd;
    logic [CW-1:0] setx_c, xlim_c, step_x;
    logic [BW-1:0] sety_c, ylim_c, step_y;

    dras_clamp #(.W(CW), .MAXV(MAX_X)) u_clamp_setx (.raw(setx_val), .lim(setx_c));
    dras_clamp #(.W(BW), .MAXV(MAX_Y)) u_clamp_sety (.raw(sety_val), .lim(sety_c));
    dras_clamp #(.W(CW), .MAXV(MAX_X)) u_clamp_xlim (.raw(xlim_val), .lim(xlim_c));
    dras_clamp #(.W(BW), .MAXV(MAX_Y)) u_clamp_ylim (.raw(ylim_val), .lim(ylim_c));

    dras_step #(.CW(CW), .BW(BW)) u_step (
        .x    (st_q.x),
        .y    (st_q.y),
        .xlim (st_q.xlim),
        .ylim (st_q.ylim),
        .ord  (st_q.ord),
        .nx   (step_x),
        .ny   (step_y)
    );

    dras_mirror #(.CW(CW), .NUM_COLS(NUM_COLS)) u_mirror (
        .x      (st_q.x),
        .mirror (st_q.mirror),
        .col    (col_addr)
    );

    always_comb begin
        any_cmd = setx_stb | sety_stb | xlim_stb | ylim_stb | mode_stb;
        st_d    = st_q;
        if (byte_stb && !any_cmd) begin
            st_d.x = step_x;
            st_d.y = step_y;
        end
        if (setx_stb) st_d.x    = setx_c;
        if (sety_stb) st_d.y    = sety_c;
        if (xlim_stb) st_d.xlim = xlim_c;
        if (ylim_stb) st_d.ylim = ylim_c;
        if (mode_stb) begin
            st_d.ord    = mode_vert ? ORD_VERT : ORD_HORZ;
            st_d.mirror = mode_mirror;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign wr_en     = byte_stb;
    assign bank_addr = st_q.y;

    AST_X_IN_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.x) <= MAX_X); // R6
    AST_Y_IN_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.y) <= MAX_Y); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_stb && !any_cmd) |=> ($stable(col_addr) && $stable(bank_addr))); // R2
    AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !any_cmd && st_q.ord == ORD_HORZ && st_q.x < st_q.xlim)
        |=> (st_q.x == $past(st_q.x) + 1'b1 && $stable(st_q.y))); // R3
    AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !any_cmd && st_q.ord == ORD_HORZ && st_q.x >= st_q.xlim)
        |=> (st_q.x == '0)); // R3
    AST_V_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !any_cmd && st_q.ord == ORD_VERT && st_q.y < st_q.ylim)
        |=> (st_q.y == $past(st_q.y) + 1'b1 && $stable(st_q.x))); // R4
    AST_V_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !any_cmd && st_q.ord == ORD_VERT && st_q.y >= st_q.ylim)
        |=> (st_q.y == '0)); // R4
    AST_MIRROR_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mirror |-> (int'(col_addr) + int'(st_q.x) == MAX_X)); // R5
    AST_SETX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (setx_stb && int'(setx_val) <= MAX_X) |=> (st_q.x == $past(setx_val))); // R6
    AST_CMD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !setx_stb && !sety_stb && (xlim_stb || ylim_stb || mode_stb))
        |=> ($stable(st_q.x) && $stable(st_q.y))); // R9
endmodule

// File: tb/tb_dras_addr_seq.sv
module tb_dras_addr_seq;
    localparam int NC = 102;
    localparam int NB = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_stb = 1'b0;
    logic       setx_stb = 1'b0;
    logic [6:0] setx_val = '0;
    logic       sety_stb = 1'b0;
    logic [3:0] sety_val = '0;
    logic       xlim_stb = 1'b0;
    logic [6:0] xlim_val = '0;
    logic       ylim_stb = 1'b0;
    logic [3:0] ylim_val = '0;
    logic       mode_stb = 1'b0;
    logic       mode_vert = 1'b0;
    logic       mode_mirror = 1'b0;
    logic       wr_en;
    logic [6:0] col_addr;
    logic [3:0] bank_addr;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    // reference model
    int ex, ey, exl, eyl;
    bit ev, em;
    int hits [NB][NC];

    always #5 clk = ~clk;

    dras_addr_seq dut (
        .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb),
        .setx_stb(setx_stb), .setx_val(setx_val),
        .sety_stb(sety_stb), .sety_val(sety_val),
        .xlim_stb(xlim_stb), .xlim_val(xlim_val),
        .ylim_stb(ylim_stb), .ylim_val(ylim_val),
        .mode_stb(mode_stb), .mode_vert(mode_vert), .mode_mirror(mode_mirror),
        .wr_en(wr_en), .col_addr(col_addr), .bank_addr(bank_addr)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic put(bit b, bit sx, int sxv, bit sy, int syv, bit xl, int xlv,
                       bit yl, int ylv, bit md, bit mv, bit mm);
        @(negedge clk);
        byte_stb = b;
        setx_stb = sx; setx_val = 7'(sxv);
        sety_stb = sy; sety_val = 4'(syv);
        xlim_stb = xl; xlim_val = 7'(xlv);
        ylim_stb = yl; ylim_val = 4'(ylv);
        mode_stb = md; mode_vert = mv; mode_mirror = mm;
        #2;
    endtask

    function automatic int clampi(int v, int m);
        return (v > m) ? m : v;
    endfunction

    function automatic int exp_col();
        return em ? (NC - 1 - ex) : ex;
    endfunction

    task automatic model_step();
        if (!ev) begin
            if (ex >= exl) begin ex = 0; ey = (ey >= eyl) ? 0 : ey + 1; end
            else ex = ex + 1;
        end else begin
            if (ey >= eyl) begin ey = 0; ex = (ex >= exl) ? 0 : ex + 1; end
            else ey = ey + 1;
        end
    endtask

    task automatic check_addr(string req, int wexp);
        chk(req, "wr_en", int'(wr_en), wexp);
        chk(req, "col_addr", int'(col_addr), exp_col());
        chk(req, "bank_addr", int'(bank_addr), ey);
    endtask

    task automatic do_byte(string req);
        put(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check_addr(req, 1);
        if (int'(bank_addr) < NB && int'(col_addr) < NC)
            hits[bank_addr][col_addr]++;
        model_step();
    endtask

    task automatic peek(string req);
        put(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check_addr(req, 0);
    endtask

    task automatic set_x(int v);
        put(0, 1, v, 0, 0, 0, 0, 0, 0, 0, 0, 0); ex = clampi(v, NC - 1);
    endtask
    task automatic set_y(int v);
        put(0, 0, 0, 1, v, 0, 0, 0, 0, 0, 0, 0); ey = clampi(v, NB - 1);
    endtask
    task automatic set_xlim(int v);
        put(0, 0, 0, 0, 0, 1, v, 0, 0, 0, 0, 0); exl = clampi(v, NC - 1);
    endtask
    task automatic set_ylim(int v);
        put(0, 0, 0, 0, 0, 0, 0, 1, v, 0, 0, 0); eyl = clampi(v, NB - 1);
    endtask
    task automatic set_mode(bit v, bit m);
        put(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, v, m); ev = v; em = m;
    endtask

    task automatic clear_hits();
        for (int b = 0; b < NB; b++)
            for (int c = 0; c < NC; c++) hits[b][c] = 0;
    endtask

    task automatic check_hits(string req);
        int bad = 0;
        for (int b = 0; b < NB; b++)
            for (int c = 0; c < NC; c++) if (hits[b][c] != 1) bad++;
        chk(req, "cells not written exactly once", bad, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        byte_stb = 0; setx_stb = 0; sety_stb = 0; xlim_stb = 0; ylim_stb = 0; mode_stb = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        ex = 0; ey = 0; exl = NC - 1; eyl = NB - 1; ev = 0; em = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        ex = 0; ey = 0; exl = NC - 1; eyl = NB - 1; ev = 0; em = 0;
        do_reset();
        peek("R1");

        // R10 / R3: full horizontal sweep with default limits
        clear_hits();
        for (int i = 0; i < NC * NB; i++) do_byte("R3");
        check_hits("R10");
        peek("R10");

        // R8 / R4 / R5: full vertical sweep, mirrored
        set_mode(1, 1);
        peek("R8");
        clear_hits();
        for (int i = 0; i < NC * NB; i++) do_byte("R4");
        check_hits("R10");
        peek("R5");

        // R10: horizontal mirrored sweep
        set_mode(0, 1);
        clear_hits();
        for (int i = 0; i < NC * NB; i++) do_byte("R5");
        check_hits("R10");

        // R7: reduced limits in both orders
        set_mode(0, 0);
        set_xlim(9);
        set_ylim(3);
        set_x(0);
        set_y(0);
        for (int i = 0; i < 60; i++) do_byte("R7");
        set_mode(1, 0);
        for (int i = 0; i < 60; i++) do_byte("R7");

        // R6: clamped pointer loads
        set_x(120);
        peek("R6");
        set_y(15);
        peek("R6");
        set_x(57);
        set_y(2);
        peek("R6");

        // R7: clamped limit loads, observed through wraps
        set_mode(0, 0);
        set_xlim(127);
        set_ylim(12);
        set_x(99);
        set_y(7);
        for (int i = 0; i < 8; i++) do_byte("R7");

        // R3: pointer loaded beyond the limit wraps at once
        set_xlim(5);
        set_x(50);
        set_y(1);
        do_byte("R3");
        peek("R3");
        set_mode(1, 0);
        set_ylim(2);
        set_y(6);
        do_byte("R4");
        peek("R4");

        // R9: command coinciding with a byte
        set_mode(0, 0);
        set_x(3);
        set_y(0);
        put(1, 0, 0, 0, 0, 1, 40, 0, 0, 0, 0, 0);
        check_addr("R9", 1);
        exl = 40;
        peek("R9");
        put(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1);
        check_addr("R9", 1);
        ev = 1; em = 1;
        peek("R9");
        put(1, 0, 0, 1, 6, 0, 0, 0, 0, 0, 0, 0);
        check_addr("R9", 1);
        ey = 6;
        peek("R9");

        // R2: idle cycles keep the address still
        for (int i = 0; i < 5; i++) peek("R2");

        // R1: reset again mid-run restores the defaults
        do_reset();
        peek("R1");
        do_byte("R1");
        do_byte("R1");
        peek("R1");

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule